// File: doc/BRIEF.md
# Slip-Aligned Serial-to-Word Deserializer

This block turns a serial bit stream into parallel words of a programmable length between 4 and 10 bits. Serial bits arrive one per accepted beat. The parallel word boundary falls every `word_len` accepted bits, and the word leaves through a valid/ready stream port. The first bit of each word lands in the top used bit, and the unused upper bits read zero.

To move the word boundary, the parallel-side logic raises `slip_req`. The level is sampled only on the beat that closes a word. Each new rising level found there adds exactly one bit of latency to the serial path, for the bits that follow. One earlier bit is fed into the shift path a second time, so every later boundary moves by one bit. The block counts these insertions. When the count would reach the programmable rollover point (1 to 11 insertions, independent of the word length), it returns to zero and `roll_flag` pulses for one clock. The two words that close after an insertion are settling and are never presented.

Back-pressure rules: a word stays on `word_data` with `word_valid` high until `word_ready` is seen high at a clock edge. The serial side is stalled (`ser_ready` low) only on the beat that would close a word to be presented while an earlier word is still held. Bits are taken only when `ser_valid` and `ser_ready` are both high.

Top module: `slip_align_deser`

## Requirements
- R1: The effective word length is `word_len` clamped to the range 4..10: values below 4 act as 4 and values above 10 act as 10. A word closes on every effective-length-th accepted serial bit. Both configuration inputs are held stable while out of reset.
- R2: In a presented word, the first serial bit of the word sits in bit (length-1) and the last one in bit 0. Bits above (length-1) are zero.
- R3: A rising level of `slip_req` seen on a word-closing beat raises the inserted latency by one bit for all later bits. The bit fed into the shift path on the following beat is the bit fed on the closing beat, a second time.
- R4: `slip_req` is sampled only on word-closing beats. A level held high over several such beats counts as one slip, and a change between closing beats has no effect.
- R5: The word that closes on the beat where a slip is taken is presented. The next two words to close are discarded. All other words are presented in order.
- R6: The effective rollover point is `roll_point` clamped to 1..11 (0 acts as 1). When an insertion would bring the count to the effective rollover point, the count returns to zero (no added latency), and `roll_flag` is high for exactly the one clock after that closing beat.
- R7: While `word_valid` is high and `word_ready` is low, `word_valid` and `word_data` hold. `ser_ready` is low exactly when the current beat would close a word to be presented while such a stalled word is held.
- R8: After reset `word_valid` and `roll_flag` are low, `ser_ready` is high, the slip count is zero, and the delay line holds zeros, so the bits that an inserted latency reaches before the first received bit read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_len | input | 4 | Requested word length, clamped to 4..10 |
| roll_point | input | 4 | Requested rollover point, clamped to 1..11 |
| slip_req | input | 1 | Slip request level, sampled on word-closing beats |
| ser_valid | input | 1 | Serial bit present |
| ser_ready | output | 1 | Serial bit can be taken |
| ser_data | input | 1 | Serial bit |
| word_valid | output | 1 | Parallel word presented |
| word_ready | input | 1 | Consumer takes the presented word |
| word_data | output | 10 | Parallel word, first bit in the top used bit |
| roll_flag | output | 1 | One-clock pulse on slip-count rollover |

## Verification
The critical overlap is a slip edge sampled on the very beat that closes a word while the consumer is stalling the previous word. The closing beat must then wait, and the slip must take effect only once that beat is finally accepted. The bench produces this by driving `word_ready` and `ser_valid` with random gaps while the slip level changes on bit counts. It covers every clamped word length against several rollover points. Each presented word is compared with a word built arithmetically from the recorded bit history and the expected inserted latency, and `ser_ready` and `roll_flag` are checked on every clock.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int MIN_WORD = 4;
  localparam int DEF_MAX_WORD = 10;
  localparam int DEF_MAX_ROLL = 11;
  localparam int SETTLE_WORDS = 2;
endpackage

// File: rtl/bsd_slip_ctrl.sv
module bsd_slip_ctrl #(
  parameter int MAX_ROLL = 11,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary,
  input  logic          slip_lvl,
  input  logic [CW-1:0] roll_pt,
  output logic [CW-1:0] slip_cnt,
  output logic          roll_pulse,
  output logic          emit
);
  import bsd_pkg::*;

  logic [CW-1:0] roll_eff;
  logic          lvl_seen;
  logic [1:0]    settle;
  logic          take;
  logic [CW:0]   cnt_inc;

  always_comb begin
    if (roll_pt == '0) roll_eff = CW'(1);
    else if (roll_pt > CW'(MAX_ROLL)) roll_eff = CW'(MAX_ROLL);
    else roll_eff = roll_pt;
  end

  assign take    = boundary && slip_lvl && !lvl_seen;
  assign cnt_inc = {1'b0, slip_cnt} + (CW+1)'(1);
  assign emit    = (settle == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_seen   <= 1'b0;
      settle     <= 2'd0;
      slip_cnt   <= '0;
      roll_pulse <= 1'b0;
    end else begin
      roll_pulse <= 1'b0;
      if (boundary) begin
        lvl_seen <= slip_lvl;
        if (take) settle <= 2'(SETTLE_WORDS);
        else if (settle != 2'd0) settle <= settle - 2'd1;
      end
      if (take) begin
        if (cnt_inc >= {1'b0, roll_eff}) begin
          slip_cnt   <= '0;
          roll_pulse <= 1'b1;
        end else begin
          slip_cnt <= cnt_inc[CW-1:0];
        end
      end
    end
  end

  AST_ROLL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    roll_pulse |=> !roll_pulse); // R6
  AST_CNT_BELOW_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    slip_cnt < roll_eff); // R6
  AST_CNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(slip_cnt)); // R4
endmodule

// File: rtl/bsd_bit_delay.sv
module bsd_bit_delay #(
  parameter int DEPTH = 10,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          din,
  input  logic [CW-1:0] sel,
  output logic          dout
);
  logic [DEPTH-1:0] line;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line <= '0;
        else if (adv) line <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line <= '0;
        else if (adv) line <= {line[DEPTH-2:0], din};
      end
    end
  endgenerate

  always_comb begin
    dout = din;
    for (int i = 1; i <= DEPTH; i++) begin
      if (sel == CW'(i)) dout = line[i-1];
    end
  end

  AST_TAP_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    sel <= CW'(DEPTH)); // R6
endmodule

// File: rtl/bsd_word_collect.sv
module bsd_word_collect #(
  parameter int MAX_WORD = 10,
  parameter int LW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LW-1:0]       word_len,
  input  logic                bit_valid,
  input  logic                bit_in,
  input  logic                emit,
  input  logic                out_ready,
  output logic                ser_ready,
  output logic                accept,
  output logic                boundary,
  output logic                out_valid,
  output logic [MAX_WORD-1:0] out_word
);
  import bsd_pkg::*;

  logic [LW-1:0]       len_eff;
  logic [LW-1:0]       beat_cnt;
  logic [MAX_WORD-1:0] col;
  logic [MAX_WORD-1:0] col_next;
  logic                last;

  always_comb begin
    if (word_len < LW'(MIN_WORD)) len_eff = LW'(MIN_WORD);
    else if (word_len > LW'(MAX_WORD)) len_eff = LW'(MAX_WORD);
    else len_eff = word_len;
  end

  assign last      = (beat_cnt == len_eff - LW'(1));
  assign ser_ready = !(last && emit && out_valid && !out_ready);
  assign accept    = bit_valid && ser_ready;
  assign boundary  = accept && last;
  assign col_next  = {((beat_cnt == '0) ? '0 : col[MAX_WORD-2:0]), bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_cnt  <= '0;
      col       <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      if (accept) begin
        col      <= col_next;
        beat_cnt <= last ? '0 : beat_cnt + LW'(1);
      end
      if (boundary && emit) begin
        out_word  <= col_next;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    beat_cnt < len_eff); // R1
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word)); // R7
  AST_NO_LOST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && emit |-> !(out_valid && !out_ready)); // R7
endmodule

// File: rtl/slip_align_deser.sv
module slip_align_deser #(
  parameter int MAX_WORD = bsd_pkg::DEF_MAX_WORD,
  parameter int MAX_ROLL = bsd_pkg::DEF_MAX_ROLL
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          word_len,
  input  logic [3:0]          roll_point,
  input  logic                slip_req,
  input  logic                ser_valid,
  output logic                ser_ready,
  input  logic                ser_data,
  output logic                word_valid,
  input  logic                word_ready,
  output logic [MAX_WORD-1:0] word_data,
  output logic                roll_flag
);
  localparam int LW    = 4;
  localparam int CW    = 4;
  localparam int DEPTH = MAX_ROLL - 1;

  logic [CW-1:0] slip_cnt;
  logic          tap_bit;
  logic          accept;
  logic          boundary;
  logic          emit;

  bsd_slip_ctrl #(.MAX_ROLL(MAX_ROLL), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary   (boundary),
    .slip_lvl   (slip_req),
    .roll_pt    (roll_point),
    .slip_cnt   (slip_cnt),
    .roll_pulse (roll_flag),
    .emit       (emit)
  );

  bsd_bit_delay #(.DEPTH(DEPTH), .CW(CW)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (accept),
    .din   (ser_data),
    .sel   (slip_cnt),
    .dout  (tap_bit)
  );

  bsd_word_collect #(.MAX_WORD(MAX_WORD), .LW(LW)) u_coll (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_len  (word_len),
    .bit_valid (ser_valid),
    .bit_in    (tap_bit),
    .emit      (emit),
    .out_ready (word_ready),
    .ser_ready (ser_ready),
    .accept    (accept),
    .boundary  (boundary),
    .out_valid (word_valid),
    .out_word  (word_data)
  );

  AST_ROLL_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    roll_flag |-> $past(boundary && slip_req)); // R6
endmodule

// File: tb/tb_slip_align_deser.sv
module tb_slip_align_deser;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] word_len = 4'd4;
  logic [3:0] roll_point = 4'd1;
  logic       slip_req = 1'b0;
  logic       ser_valid = 1'b0;
  logic       ser_data = 1'b0;
  logic       word_ready = 1'b0;
  logic       ser_ready;
  logic       word_valid;
  logic [9:0] word_data;
  logic       roll_flag;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  int hist [4096];
  int n, bc, d, drop, lf, rf;
  logic [9:0] col;
  bit sprev, roll_exp, prev_stall;
  logic [9:0] prev_word;
  logic [9:0] expq [$];

  slip_align_deser dut (
    .clk(clk), .rst_n(rst_n), .word_len(word_len), .roll_point(roll_point),
    .slip_req(slip_req), .ser_valid(ser_valid), .ser_ready(ser_ready),
    .ser_data(ser_data), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .roll_flag(roll_flag)
  );

  always #10 clk = ~clk;

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got %0d cycles, expected fewer than 190000", cyc);
      report();
      $finish;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (len %0d roll %0d beat %0d)",
               req, act, exp, lf, rf, n);
    end
  endtask

  // One clock: check registered outputs, drive, predict, advance the model.
  task automatic one_cycle(bit active, int vpct, int rpct, int hlen, int llen);
    bit exp_rdy, tap, edge_s;
    check(roll_flag == roll_exp, "R6 roll_flag", roll_flag, roll_exp);
    roll_exp = 1'b0;
    if (prev_stall)
      check(word_valid && word_data == prev_word, "R7 hold", word_data, prev_word);
    ser_valid  = active && (($urandom % 100) < vpct);
    ser_data   = 1'($urandom);
    word_ready = (($urandom % 100) < rpct);
    slip_req   = ((n % (hlen + llen)) >= llen);
    #1;
    exp_rdy = !(bc == lf - 1 && drop == 0 && word_valid && !word_ready);
    check(ser_ready == exp_rdy, "R7 ser_ready", ser_ready, exp_rdy);
    if (word_valid && word_ready) begin
      if (expq.size() == 0) check(1'b0, "R5 unexpected word", word_data, 0);
      else begin
        logic [9:0] e;
        e = expq.pop_front();
        check(word_data == e, "R2 R3 R5 word", word_data, e);
      end
    end
    prev_stall = word_valid && !word_ready;
    prev_word  = word_data;
    if (ser_valid && ser_ready) begin
      hist[n] = ser_data;
      tap = (n - d >= 0) ? 1'(hist[n - d]) : 1'b0;  // R8 zero-filled line
      col = ((bc == 0) ? 10'd0 : col) << 1 | 10'(tap);
      bc++;
      n++;
      if (bc == lf) begin                            // R1 boundary
        bc = 0;
        if (drop == 0) expq.push_back(col);
        edge_s = slip_req && !sprev;                 // R4 sampled here only
        sprev = slip_req;
        drop = edge_s ? 2 : ((drop > 0) ? drop - 1 : 0);
        if (edge_s) begin                            // R3
          if (d + 1 >= rf) begin d = 0; roll_exp = 1'b1; end
          else d++;
        end
      end
    end
    @(posedge clk);
    #9;
  endtask

  task automatic run_cfg(int wl, int rp, int words, int vpct, int rpct);
    int hlen, llen;
    lf = (wl < 4) ? 4 : (wl > 10) ? 10 : wl;
    rf = (rp < 1) ? 1 : (rp > 11) ? 11 : rp;
    hlen = lf * ((rp % 3) + 1);
    llen = lf + 1 + rp;
    rst_n = 1'b0; ser_valid = 1'b0; word_ready = 1'b0; slip_req = 1'b0;
    word_len = 4'(wl); roll_point = 4'(rp);
    n = 0; bc = 0; d = 0; drop = 0; col = '0; sprev = 0; roll_exp = 0;
    prev_stall = 0; expq.delete();
    repeat (3) @(posedge clk);
    #9 rst_n = 1'b1;
    #2;
    check(word_valid == 1'b0, "R8 reset word_valid", word_valid, 0);
    check(roll_flag == 1'b0, "R8 reset roll_flag", roll_flag, 0);
    check(ser_ready == 1'b1, "R8 reset ser_ready", ser_ready, 1);
    @(posedge clk);
    #9;
    while (n < words * lf) one_cycle(1'b1, vpct, rpct, hlen, llen);
    repeat (6) one_cycle(1'b0, 0, 100, hlen, llen);
    check(expq.size() == 0, "R5 words left over", expq.size(), 0);
  endtask

  initial begin
    int lens[9] = '{4, 5, 6, 7, 8, 9, 10, 2, 13};
    int rolls[5] = '{1, 4, 11, 0, 14};
    foreach (lens[i]) begin
      foreach (rolls[j]) begin
        if (j % 2 == 0) run_cfg(lens[i], rolls[j], 40, 100, 100);
        else run_cfg(lens[i], rolls[j], 40, 75, 60);
      end
    end
    report();
    $finish;
  end
endmodule